// File: doc/BRIEF.md
# Floating-Point Structural Hazard Issue Checker

This block decides at issue time whether a floating-point operation may enter a pipelined FP unit. In that unit the adder and multiplier share sub-stages, and each operation class holds a fixed set of them in a fixed order over the cycles after issue. The multiplier's last steps use the adder's add and round stages, so a multiply and a later add can need the same stage in the same cycle. Whether they do depends only on how far apart they issue.

The checker keeps a table of future cycles. Each row is a bit vector holding one bit per shared stage. When a request arrives, the checker compares the operation's reservation pattern against the rows it would occupy. If none of the bits overlap, it grants the request and ORs the pattern into the table. If any bit overlaps, it raises a stall, and the requester tries again in the next cycle. The table advances by one row every clock, and the row for the current cycle is visible at an output. Only one request can be presented per cycle.

Top module: `fp_hz_issue_chk`

## Requirements
- R1: Resource bits are unpack = bit 0, shift = bit 1, mantissa add = bit 2, round = bit 3, exception test = bit 4, multiply stage one = bit 5, multiply stage two = bit 6. `res_now` shows the stages reserved for the current cycle. A synchronous reset clears every reservation, so `res_now` reads 0 after reset.
- R2: Op code 0 (add/subtract) reserves the following stages after issue: unpack in the first cycle, shift and add in the second, add and round in the third, round and shift in the fourth.
- R3: Op code 1 (multiply) reserves the following stages after issue: unpack in cycle 1, exception and multiply-one in cycle 2, multiply-one in cycles 3, 4 and 5, multiply-two in cycle 6, multiply-two and add in cycle 7, round in cycle 8.
- R4: Op code 2 (compare) reserves unpack, add and round in cycles 1, 2 and 3. Op codes 3 (negate) and 4 (absolute value) each reserve unpack in cycle 1 and shift in cycle 2.
- R5: A valid request with a known op code is granted in the same cycle exactly when none of its pattern bits overlap a reservation already held for the same future cycle. Otherwise `stall` is raised. `grant` and `stall` are never high together.
- R6: A request granted in cycle c shows stage k of its pattern in `res_now` during cycle c+k, ORed with the earlier reservations.
- R7: A stalled request adds nothing to the table. The same request presented again in a later cycle is granted once its pattern no longer collides.
- R8: Op codes 5 to 7 raise neither `grant` nor `stall` and leave the table unchanged. When no request is granted for 8 cycles, the table is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An issue request is present this cycle |
| req_op | input | 3 | Operation class code of the request |
| grant | output | 1 | Request accepted; its pattern is reserved at the clock edge |
| stall | output | 1 | Request collides with a held reservation |
| res_now | output | 7 | Stages reserved for the current cycle |

## Verification
The table's one-row shift and the merge of a newly granted pattern happen on the same clock edge. The collision test in that cycle also reads the rows that the shift is about to move. The bench provokes this by issuing requests at chosen distances after a multiply. For example, an add issued four cycles after a multiply must stall, because both need the add stage in the same cycle. It also sends back-to-back adds and dense random mixes. A bench model built from the listed patterns predicts `grant`, `stall` and the current-cycle row. Those predictions are compared with the outputs in every cycle before the edge.

// File: rtl/fp_hz_pkg.sv
package fp_hz_pkg;

    localparam int NUM_RES = 7;
    localparam int PAT_LEN = 8;
    localparam int OP_W    = 3;

    localparam int RB_UNPACK = 0;
    localparam int RB_SHIFT  = 1;
    localparam int RB_ADD    = 2;
    localparam int RB_ROUND  = 3;
    localparam int RB_EXC    = 4;
    localparam int RB_MUL1   = 5;
    localparam int RB_MUL2   = 6;

    typedef enum logic [OP_W-1:0] {
        OPC_ADDSUB = 3'd0,
        OPC_MUL    = 3'd1,
        OPC_CMP    = 3'd2,
        OPC_NEG    = 3'd3,
        OPC_ABS    = 3'd4
    } fp_opc_e;

    typedef logic [NUM_RES-1:0]              res_vec_t;
    typedef logic [PAT_LEN-1:0][NUM_RES-1:0] pat_t;

    typedef struct packed {
        logic known;
        pat_t pat;
    } op_desc_t;

    function automatic res_vec_t rbit(input int idx);
        res_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    function automatic op_desc_t decode_op(input logic [OP_W-1:0] code);
        op_desc_t d;
        d.known = 1'b1;
        d.pat   = '0;
        case (code)
            OPC_ADDSUB: begin
                d.pat[0] = rbit(RB_UNPACK);
                d.pat[1] = rbit(RB_SHIFT) | rbit(RB_ADD);
                d.pat[2] = rbit(RB_ADD)   | rbit(RB_ROUND);
                d.pat[3] = rbit(RB_ROUND) | rbit(RB_SHIFT);
            end
            OPC_MUL: begin
                d.pat[0] = rbit(RB_UNPACK);
                d.pat[1] = rbit(RB_EXC) | rbit(RB_MUL1);
                d.pat[2] = rbit(RB_MUL1);
                d.pat[3] = rbit(RB_MUL1);
                d.pat[4] = rbit(RB_MUL1);
                d.pat[5] = rbit(RB_MUL2);
                d.pat[6] = rbit(RB_MUL2) | rbit(RB_ADD);
                d.pat[7] = rbit(RB_ROUND);
            end
            OPC_CMP: begin
                d.pat[0] = rbit(RB_UNPACK);
                d.pat[1] = rbit(RB_ADD);
                d.pat[2] = rbit(RB_ROUND);
            end
            OPC_NEG, OPC_ABS: begin
                d.pat[0] = rbit(RB_UNPACK);
                d.pat[1] = rbit(RB_SHIFT);
            end
            default: d.known = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fp_hz_pattern.sv
module fp_hz_pattern
    import fp_hz_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output op_desc_t        desc
);

    always_comb desc = decode_op(op_code);

endmodule

// File: rtl/fp_hz_collide.sv
module fp_hz_collide
    import fp_hz_pkg::*;
#(
    parameter int DEPTH = PAT_LEN
) (
    input  logic [DEPTH-1:0][NUM_RES-1:0] slots,
    input  pat_t                          pat,
    output logic                          hit
);

    logic [PAT_LEN-1:0] stage_hit;

    for (genvar k = 0; k < PAT_LEN; k++) begin : g_stage
        if (k + 1 < DEPTH) begin : g_cmp
            assign stage_hit[k] = |(pat[k] & slots[k+1]);
        end else begin : g_none
            assign stage_hit[k] = 1'b0;
        end
    end

    assign hit = |stage_hit;

endmodule

// File: rtl/fp_hz_table.sv
module fp_hz_table
    import fp_hz_pkg::*;
#(
    parameter int DEPTH = PAT_LEN
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          merge_en,
    input  pat_t                          merge_pat,
    output logic [DEPTH-1:0][NUM_RES-1:0] slots
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][NUM_RES-1:0] slot_q;
    logic [DEPTH-1:0][NUM_RES-1:0] slot_d;

    for (genvar j = 0; j < DEPTH; j++) begin : g_row
        res_vec_t shifted;
        res_vec_t added;
        if (j + 1 < DEPTH) begin : g_sh
            assign shifted = slot_q[j+1];
        end else begin : g_top
            assign shifted = '0;
        end
        if (j < PAT_LEN) begin : g_add
            assign added = merge_en ? merge_pat[j] : '0;
        end else begin : g_noadd
            assign added = '0;
        end
        assign slot_d[j] = shifted | added;
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    assign slots = slot_q;

    // Cycles since the last merge, saturating at the table depth.
    logic [CW-1:0] quiet_cnt;
    always_ff @(posedge clk) begin
        if (rst || merge_en)                 quiet_cnt <= '0;
        else if (quiet_cnt != CW'(DEPTH))    quiet_cnt <= quiet_cnt + 1'b1;
    end

    // R8: with no merge for a full table depth, every row has drained.
    a_r8_drain_empty: assert property (@(posedge clk) disable iff (rst)
        (quiet_cnt == CW'(DEPTH)) |-> (slot_q == '0));

endmodule

// File: rtl/fp_hz_issue_chk.sv
module fp_hz_issue_chk
    import fp_hz_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [OP_W-1:0]     req_op,
    output logic                grant,
    output logic                stall,
    output logic [NUM_RES-1:0]  res_now
);

    localparam int DEPTH = PAT_LEN;

    op_desc_t                      desc;
    logic [DEPTH-1:0][NUM_RES-1:0] slots;
    logic                          hit;
    logic                          live_req;

    fp_hz_pattern u_pattern (
        .op_code (req_op),
        .desc    (desc)
    );

    fp_hz_collide #(.DEPTH(DEPTH)) u_collide (
        .slots (slots),
        .pat   (desc.pat),
        .hit   (hit)
    );

    fp_hz_table #(.DEPTH(DEPTH)) u_table (
        .clk       (clk),
        .rst       (rst),
        .merge_en  (grant),
        .merge_pat (desc.pat),
        .slots     (slots)
    );

    assign live_req = !rst && req_valid && desc.known;
    assign grant    = live_req && !hit;
    assign stall    = live_req && hit;
    assign res_now  = slots[0];

    // R5: accept and stall are mutually exclusive.
    a_r5_excl: assert property (@(posedge clk) disable iff (rst)
        !(grant && stall));

    // R6: every pattern starts with unpack, visible one cycle after grant.
    a_r6_unpack_next: assert property (@(posedge clk) disable iff (rst)
        grant |=> res_now[RB_UNPACK]);

    // R8: unknown codes neither grant nor stall.
    a_r8_unknown_idle: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op > 3'd4) |-> (!grant && !stall));

    // R5: nothing is granted without a request.
    a_r5_need_req: assert property (@(posedge clk) disable iff (rst)
        (grant || stall) |-> req_valid);

endmodule

// File: tb/fp_hz_issue_chk_bench.sv
`timescale 1ns/1ps
module fp_hz_issue_chk_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic [2:0] req_op;
    logic       grant;
    logic       stall;
    logic [6:0] res_now;

    int checks = 0;
    int errors = 0;

    logic [6:0] mdl [0:7];

    always #10 clk = ~clk;

    fp_hz_issue_chk u_fp_hz_issue_chk (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .grant     (grant),
        .stall     (stall),
        .res_now   (res_now)
    );

    // Bits: U=0 S=1 A=2 R=3 E=4 M=5 N=6
    function automatic logic [6:0] exp_stage(input logic [2:0] op, input int k);
        logic [6:0] u, s, a, r, e, m, n;
        u = 7'h01; s = 7'h02; a = 7'h04; r = 7'h08; e = 7'h10; m = 7'h20; n = 7'h40;
        case (op)
            3'd0: case (k) 0: return u; 1: return s|a; 2: return a|r; 3: return r|s; default: return 0; endcase
            3'd1: case (k) 0: return u; 1: return e|m; 2,3,4: return m; 5: return n;
                           6: return n|a; 7: return r; default: return 0; endcase
            3'd2: case (k) 0: return u; 1: return a; 2: return r; default: return 0; endcase
            3'd3, 3'd4: case (k) 0: return u; 1: return s; default: return 0; endcase
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic step(input logic v, input logic [2:0] op, input string tag);
        bit known, col, eg, es;
        @(negedge clk);
        req_valid = v;
        req_op    = op;
        #1;
        known = (op <= 3'd4);
        col = 1'b0;
        for (int k = 0; k < 7; k++)
            if ((exp_stage(op, k) & mdl[k+1]) != 0) col = 1'b1;
        eg = v && known && !col;
        es = v && known && col;
        chk(res_now == mdl[0], tag, "res_now", res_now, mdl[0]);
        chk(grant == eg, tag, "grant", grant, eg);
        chk(stall == es, tag, "stall", stall, es);
        for (int j = 0; j < 8; j++)
            mdl[j] = ((j < 7) ? mdl[j+1] : 7'h0) | (eg ? exp_stage(op, j) : 7'h0);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, tag);
    endtask

    initial begin
        #3000000;
        checks++;
        errors++;
        $display("FAIL R5 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int j = 0; j < 8; j++) mdl[j] = '0;
        rst = 1'b1; req_valid = 1'b0; req_op = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle(2, "R1");

        // R3: isolated multiply, watch it walk through res_now
        step(1'b1, 3'd1, "R3");
        idle(9, "R3");
        // R2: isolated add
        step(1'b1, 3'd0, "R2");
        idle(5, "R2");
        // R4: compare, negate, absolute value
        step(1'b1, 3'd2, "R4"); idle(4, "R4");
        step(1'b1, 3'd3, "R4"); idle(3, "R4");
        step(1'b1, 3'd4, "R4"); idle(3, "R4");
        // R7: add four cycles after multiply collides on the add stage, retry
        step(1'b1, 3'd1, "R7");
        idle(3, "R7");
        for (int i = 0; i < 6; i++) step(1'b1, 3'd0, "R7");
        idle(9, "R7");
        // R5: back-to-back adds at distances 1, 2, 3
        step(1'b1, 3'd0, "R5"); step(1'b1, 3'd0, "R5");
        step(1'b1, 3'd0, "R5"); step(1'b1, 3'd0, "R5");
        idle(5, "R5");
        // R8: unknown codes while busy and while idle
        step(1'b1, 3'd1, "R8");
        step(1'b1, 3'd5, "R8"); step(1'b1, 3'd6, "R8"); step(1'b1, 3'd7, "R8");
        idle(9, "R8");
        step(1'b1, 3'd7, "R8");
        idle(2, "R8");
        // R6: dense random mix
        for (int i = 0; i < 4000; i++)
            step(($urandom % 10) < 7, 3'($urandom % 8), "R6");
        idle(9, "R6");
        // R1: reset clears a busy table
        step(1'b1, 3'd1, "R1");
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int j = 0; j < 8; j++) mdl[j] = '0;
        #1;
        chk(res_now == 7'h0, "R1", "res_now after reset", res_now, 0);
        idle(3, "R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule